// File: doc/BRIEF.md
# Half-Step Clock Divider (divide by N + 0.5)

The block turns an input clock into a pulse train whose period is N + 0.5 input periods. N is set by a parameter, and its default of 2 gives a divide-by-2.5 output. A single counter runs on the rising edge and cycles through 2N + 1 states. From that counter the block decodes a lead waveform, which is high for N + 1 counts. It also decodes a second term, and a register clocked on the falling edge captures it. That register holds a copy of the lead waveform delayed by N + 0.5 input periods. The output is the AND of the two registered waveforms. Each output pulse is therefore half an input period wide, and two pulses fall in every 2N + 1 input periods.

The output is not square. Every pulse is high for one half input period. With the default setting this is a 20% duty cycle. Successive pulses start alternately on a rising input edge and on a falling input edge. The block suits a place that needs an event rate at a fractional ratio of the clock and does not need a balanced waveform. An active-low asynchronous reset clears all state. After reset, the output stays low until the counter has completed one full lap.

Top module: `clk_n5_div`

## Requirements
- R1: Once running, consecutive rising edges of `clk_o` are exactly N + 0.5 input clock periods apart (2.5 periods for the default N = 2).
- R2: Every high pulse of `clk_o` lasts exactly half an input clock period, so the duty cycle is 1/(2N+1) and not 50%.
- R3: Any window of 2N + 1 input clock periods, taken once the output is running, contains exactly two rising edges of `clk_o`.
- R4: After reset is released, `clk_o` stays low through the first 2N + 1 rising edges of `clk_i` except the last of them. Counting the first rising edge after release as edge 1, the first output pulse starts on edge 2N + 1.
- R5: Output pulses alternate in phase. The first one after reset starts on a rising edge of `clk_i`, the next on a falling edge, and so on.
- R6: Driving `rst_ni` low forces `clk_o` low at once, even in the middle of a pulse, and keeps it low while reset is held. Releasing reset restarts the sequence described in R4.
- R7: Both waveforms derive from one modulo-(2N+1) counter, which counts 0 to 2N and wraps. The falling-edge copy seen at each rising edge equals the decode (count >= N) of the counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock; both of its edges are used |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_o | output | 1 | Divided pulse train, period N + 0.5 input periods |

## Verification
The assertions assume that `clk_i` is a free-running clock with even high and low phases. They also assume that reset is the only disturbance, and they are disabled while reset is held. The stimulus keeps a fixed 50% clock throughout. It releases reset only two time units after a falling edge, well away from either edge of `clk_i`, so the counter and the falling-edge stage come out of reset in a defined order. Reset is applied again in the middle of an output pulse. Expected pulse times are then rebased on the first rising edge after the new release.

// File: rtl/clk_n5_pkg.sv
`timescale 1ns/1ps
package clk_n5_pkg;
  // states in one counter lap for ratio n + 0.5
  function automatic int unsigned lap_len(int unsigned n);
    return 2 * n + 1;
  endfunction

  function automatic int unsigned cnt_bits(int unsigned n);
    return (lap_len(n) < 2) ? 1 : $clog2(lap_len(n));
  endfunction
endpackage

// File: rtl/n5_phase_counter.sv
`timescale 1ns/1ps
module n5_phase_counter
  import clk_n5_pkg::*;
#(
  parameter int unsigned DIV_INT = 2,
  localparam int unsigned CW     = cnt_bits(DIV_INT),
  localparam int unsigned LAST   = lap_len(DIV_INT) - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o,
  output logic          armed_o,
  output logic          lead_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  logic          lead_q;
  logic          wrap_w;

  assign wrap_w  = (cnt_q == CW'(LAST));
  assign cnt_d   = wrap_w ? '0 : cnt_q + 1'b1;
  assign armed_d = armed_q | wrap_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      lead_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      // registered decode of next state: no comparator glitch on the output
      lead_q  <= armed_d && (cnt_d <= CW'(DIV_INT));
    end
  end

  assign cnt_o   = cnt_q;
  assign armed_o = armed_q;
  assign lead_o  = lead_q;

  // R7
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LAST));
  // R7
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q == (($past(cnt_q) == CW'(LAST)) ? '0 : $past(cnt_q) + 1'b1)));
  // R4
  arm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> armed_q);
  // R4
  arm_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> ($stable(armed_q) || !$past(rst_ni)));
endmodule

// File: rtl/n5_half_shift.sv
`timescale 1ns/1ps
module n5_half_shift (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  // captures on the falling edge: half a period after the counter moves
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/clk_n5_div.sv
`timescale 1ns/1ps
module clk_n5_div
  import clk_n5_pkg::*;
#(
  parameter int unsigned DIV_INT = 2,
  localparam int unsigned CW     = cnt_bits(DIV_INT)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic clk_o
);
  logic [CW-1:0] cnt_w;
  logic          armed_w;
  logic          lead_w;
  logic          trail_d;
  logic          trail_q;

  n5_phase_counter #(.DIV_INT(DIV_INT)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_o   (cnt_w),
    .armed_o (armed_w),
    .lead_o  (lead_w)
  );

  // lead delayed by DIV_INT counts, then half a period more in the stage
  assign trail_d = (cnt_w >= CW'(DIV_INT));

  n5_half_shift u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (trail_d),
    .q_o    (trail_q)
  );

  // inputs change on opposite edges: no simultaneous transitions
  assign clk_o = lead_w & trail_q;

  // R7
  trail_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_q == (cnt_w >= CW'(DIV_INT)));
  // R4
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_w |-> !clk_o);
  // R5
  late_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_o == (armed_w && cnt_w == CW'(DIV_INT)));
  // R5
  early_pulse_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    clk_o == (armed_w && cnt_w == '0));
  // R2
  short_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_o |=> !clk_o);
endmodule

// File: tb/clk_n5_div_tb.sv
`timescale 1ns/1ps
module clk_n5_div_tb;
  localparam int DIV_INT = 2;
  localparam int PER     = 10;
  localparam int HALF    = PER / 2;
  localparam int LAP     = 2 * DIV_INT + 1;
  localparam int STEP    = LAP * HALF;   // R1 spacing
  localparam int WIN     = LAP * PER;    // R3 window
  localparam int NPULSE  = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic clk_o;

  int     n_chk = 0, n_bad = 0;
  bit     mon_en = 1'b0, done = 1'b0;
  int     rise_cnt = 0;
  longint exp_q[$];
  longint rise_log[$];
  longint last_rise = 0;

  clk_n5_div #(.DIV_INT(DIV_INT)) u_dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .clk_o  (clk_o)
  );

  always #(HALF) clk = ~clk;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: expected rise times after a release whose first rising edge is t1
  task automatic push_sched(longint t1, int k);
    for (int m = 0; m < k; m++)
      exp_q.push_back(t1 + longint'(2 * DIV_INT * PER) + longint'(m * STEP));
  endtask

  // monitor: scoreboard of rise times, plus pulse width
  always @(posedge clk_o) begin
    if (mon_en && rst_ni) begin
      longint t;
      t = $time;
      last_rise = t;
      rise_log.push_back(t);
      if (exp_q.size() == 0) chk(1'b0, "R1", "unexpected rise at", t, -1);
      else begin
        longint e;
        e = exp_q.pop_front();
        chk(t == e, "R1", "rise time", t, e);
      end
      rise_cnt++;
    end
  end

  always @(negedge clk_o) begin
    if (mon_en && rst_ni)
      chk(($time - last_rise) == HALF, "R2", "pulse width", $time - last_rise, HALF);
  end

  task automatic analyze(longint t1);
    int bad_win = 0, bad_alt = 0;
    longint first, last;
    first = rise_log[0];
    last  = rise_log[rise_log.size()-1];
    chk(first == t1 + longint'(2 * DIV_INT * PER), "R4", "first rise", first,
        t1 + longint'(2 * DIV_INT * PER));
    for (longint s = first; s + WIN <= last; s += HALF) begin
      int c = 0;
      foreach (rise_log[i]) if (rise_log[i] >= s && rise_log[i] < s + WIN) c++;
      if (c != 2) bad_win++;
    end
    chk(bad_win == 0, "R3", "windows without two rises", bad_win, 0);
    chk(((first - t1) % PER) == 0, "R5", "first rise phase", (first - t1) % PER, 0);
    for (int i = 1; i < rise_log.size(); i++) begin
      bit a, b;
      a = ((rise_log[i-1] - t1) % PER) != 0;
      b = ((rise_log[i]   - t1) % PER) != 0;
      if (a == b) bad_alt++;
    end
    chk(bad_alt == 0, "R5", "non-alternating phases", bad_alt, 0);
  endtask

  initial begin
    longint t1;
    #1 rst_ni = 1'b0;
    #30;
    chk(clk_o == 1'b0, "R6", "output in reset", clk_o, 0);
    @(negedge clk);
    #2 rst_ni = 1'b1;
    mon_en = 1'b1;
    t1 = $time + HALF - 2;
    push_sched(t1, NPULSE);
    repeat (2 * DIV_INT) @(posedge clk);
    #(PER - 1);
    chk(rise_cnt == 0, "R4", "rises during first lap", rise_cnt, 0);
    chk(clk_o == 1'b0, "R4", "output during first lap", clk_o, 0);
    wait (rise_cnt == NPULSE);
    #1 rst_ni = 1'b0;   // mid-pulse reset
    #1;
    chk(clk_o == 1'b0, "R6", "output right after reset", clk_o, 0);
    chk(exp_q.size() == 0, "R1", "missing rises", exp_q.size(), 0);
    analyze(t1);
    rise_log.delete();
    exp_q.delete();
    rise_cnt = 0;
    repeat (3) @(negedge clk);
    chk(clk_o == 1'b0, "R6", "output while reset held", clk_o, 0);
    #2 rst_ni = 1'b1;
    t1 = $time + HALF - 2;
    push_sched(t1, NPULSE);
    wait (rise_cnt == NPULSE);
    #(PER);
    chk(exp_q.size() == 0, "R6", "missing rises after restart", exp_q.size(), 0);
    analyze(t1);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(PER * 20000);
    if (!done) begin
      chk(1'b0, "R1", "watchdog expired, rises seen", rise_cnt, NPULSE);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule